// File: doc/BRIEF.md
# Table-Driven Packet Header Parser

This block extracts protocol header fields from a packet by walking a parse graph that is held in a small ternary lookup table rather than in fixed case logic. A packet arrives one byte per cycle, framed by start and end markers, and is stored in a local byte window. Once the last byte is in, the parser steps through the graph one lookup per cycle. Each step forms a key from the current parse state and a 16-bit lookahead word, which is read from the window at an offset configured for that state. The key is matched against every table entry at once.

The matching entry with the lowest index gives the next state, how many bytes to skip to reach the next header, and up to two 16-bit words to copy into numbered slots of a packet header vector. Each slot carries its own valid bit. Parsing stops cleanly on an explicit end state or when the next header would start at or beyond the end of the packet. A lookup that matches nothing ends the parse and raises an error flag. A runaway graph is cut off by a step limit. Software loads the table and the per-state lookahead offsets through a configuration port while the parser is idle. With this it can build an Ethernet → IPv4/IPv6 → TCP/UDP graph or any other.

Top module: `hdr_parser`

## Requirements
- R1: After reset, done_o and err_o are 0, every header vector valid bit is 0, and every table entry is disabled.
- R2: A table entry matches when its enable bit is 1 and the key {state[3:0], lookahead[15:0]} agrees with the entry value on every bit where the entry mask is 1. When several entries match, the lowest index wins.
- R3: The lookahead is the big-endian 16-bit word at (header base + the offset configured for the current state). Any byte at or beyond the packet length reads as zero. This holds even if the window still holds bytes from an earlier packet.
- R4: On a match, each enabled extraction slot copies the big-endian 16-bit word at (header base + slot offset) into header vector word idx and sets that word's valid bit. If both slots name the same word, slot 1's data is kept.
- R5: On a match, the header base advances by the entry's advance and the state becomes its next state. The parse ends without error when the next state is 15 or the new base is at or beyond the packet length. It then pulses done_o for exactly one cycle, one clock after the final lookup.
- R6: A lookup that matches no entry ends the parse with done_o and err_o both 1. Words extracted earlier keep their data and valid bits.
- R7: A parse that reaches MAX_STEPS lookups (default 8) without ending terminates with err_o = 1. The extractions of that final lookup still take effect.
- R8: A configuration write is taken only while the parser is idle. A write that arrives while a packet is being collected or parsed has no effect.
- R9: A start-of-packet byte taken while idle clears all valid bits and err_o. After done_o, the header vector, the valid bits and err_o hold until the next start-of-packet.
- R10: With cfg_sel_i = 0, cfg_data_i loads entry cfg_addr_i with this layout, MSB first: [70] enable, [69:66] value state, [65:50] value lookahead, [49:46] mask state, [45:30] mask lookahead, [29:26] next state, [25:20] advance, [19] slot 1 enable, [18:16] slot 1 word, [15:10] slot 1 offset, [9] slot 0 enable, [8:6] slot 0 word, [5:0] slot 0 offset. With cfg_sel_i = 1, cfg_data_i[5:0] becomes the lookahead offset of state cfg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte strobe |
| in_sop_i | input | 1 | First byte of packet |
| in_eop_i | input | 1 | Last byte of packet |
| in_data_i | input | 8 | Packet byte |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: table entry, 1: per-state lookahead offset |
| cfg_addr_i | input | 4 | Entry index or state number |
| cfg_data_i | input | 71 | Entry image or offset |
| done_o | output | 1 | One-cycle pulse at end of parse |
| err_o | output | 1 | Parse ended on a miss or on the step limit |
| phv_o | output | 128 | Header vector, word k at bits [16k+15:16k] |
| phv_vld_o | output | 8 | Valid bit per header vector word |

## Verification
Two things can happen on the same lookup. The first is two extraction slots writing one header vector word. The bench sets this up with a UDP entry whose slots both target word 4, and it expects the destination port to survive. The second is an extraction on the lookup that also ends the parse, either through the end state or through the packet running out. That lookup's words must still be valid when done_o rises. This case is provoked by a packet cut off right after its IPv4 header and by a looping entry that hits the step limit. The bench judges each case by comparing the vector, the valid mask and err_o at the done_o pulse against a scoreboard entry derived from the packet bytes.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int STW   = 4;
  localparam int WORDW = 16;
  localparam int OFFW  = 6;
  localparam int ADVW  = 6;
  localparam int WIDXW = 3;
  localparam int KEYW  = STW + WORDW;

  typedef struct packed {
    logic             en;
    logic [WIDXW-1:0] idx;
    logic [OFFW-1:0]  off;
  } slot_t;

  typedef struct packed {
    logic            vld;
    logic [KEYW-1:0] val;
    logic [KEYW-1:0] msk;
    logic [STW-1:0]  nxt;
    logic [ADVW-1:0] adv;
    slot_t           s1;
    slot_t           s0;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef enum logic [1:0] {P_IDLE, P_COLL, P_WALK} pstate_e;
endpackage

// File: rtl/hp_tcam.sv
module hp_tcam
  import hp_pkg::*;
#(
  parameter int NENT = 8
) (
  input  entry_t [NENT-1:0] tbl_i,
  input  logic [KEYW-1:0]   key_i,
  output logic              hit_o,
  output logic [STW-1:0]    nxt_o,
  output logic [ADVW-1:0]   adv_o,
  output slot_t             s0_o,
  output slot_t             s1_o
);
  logic [NENT-1:0] match;

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign match[g] = tbl_i[g].vld &&
                      (((key_i ^ tbl_i[g].val) & tbl_i[g].msk) == '0);
  end

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    hit_o = |match;
    nxt_o = '0;
    adv_o = '0;
    s0_o  = '0;
    s1_o  = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        nxt_o = tbl_i[i].nxt;
        adv_o = tbl_i[i].adv;
        s0_o  = tbl_i[i].s0;
        s1_o  = tbl_i[i].s1;
      end
    end
  end
endmodule

// File: rtl/hp_window.sv
module hp_window
  import hp_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int PW    = 8,
  parameter int NRD   = 3
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   waddr_i,
  input  logic [7:0]                 wdata_i,
  input  logic [PW-1:0]              len_i,
  input  logic [NRD-1:0][PW-1:0]     rd_pos_i,
  output logic [NRD-1:0][WORDW-1:0]  rd_word_o
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [PW-1:0] p_hi, p_lo;
    assign p_hi = rd_pos_i[g];
    assign p_lo = p_hi + PW'(1);
    // bytes past the packet length read as zero, never stale data
    assign rd_word_o[g] = {(p_hi < len_i) ? mem[p_hi[AW-1:0]] : 8'h00,
                           (p_lo < len_i) ? mem[p_lo[AW-1:0]] : 8'h00};
  end
endmodule

// File: rtl/hp_phv.sv
module hp_phv
  import hp_pkg::*;
#(
  parameter int NWORDS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     we0_i,
  input  logic [WIDXW-1:0]         idx0_i,
  input  logic [WORDW-1:0]         dat0_i,
  input  logic                     we1_i,
  input  logic [WIDXW-1:0]         idx1_i,
  input  logic [WORDW-1:0]         dat1_i,
  output logic [NWORDS*WORDW-1:0]  phv_o,
  output logic [NWORDS-1:0]        vld_o
);
  logic [NWORDS-1:0][WORDW-1:0] word_q;
  logic [NWORDS-1:0]            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= '0;
    end else if (clr_i) begin
      word_q <= '0;
      vld_q  <= '0;
    end else begin
      if (we0_i) begin
        word_q[idx0_i] <= dat0_i;
        vld_q[idx0_i]  <= 1'b1;
      end
      // slot 1 is written last so it wins a shared target
      if (we1_i) begin
        word_q[idx1_i] <= dat1_i;
        vld_q[idx1_i]  <= 1'b1;
      end
    end
  end

  assign phv_o = word_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/hdr_parser.sv
module hdr_parser
  import hp_pkg::*;
#(
  parameter int             NENT      = 8,
  parameter int             MAX_BYTES = 128,
  parameter int             MAX_STEPS = 8,
  parameter logic [STW-1:0] START_ST  = 4'd0,
  parameter logic [STW-1:0] END_ST    = 4'd15
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic                          in_sop_i,
  input  logic                          in_eop_i,
  input  logic [7:0]                    in_data_i,
  input  logic                          cfg_we_i,
  input  logic                          cfg_sel_i,
  input  logic [STW-1:0]                cfg_addr_i,
  input  logic [ENTRY_W-1:0]            cfg_data_i,
  output logic                          done_o,
  output logic                          err_o,
  output logic [(2**WIDXW)*WORDW-1:0]   phv_o,
  output logic [(2**WIDXW)-1:0]         phv_vld_o
);
  localparam int NSTATE = 2 ** STW;
  localparam int NWORDS = 2 ** WIDXW;
  localparam int BAW    = $clog2(MAX_BYTES);
  localparam int PW     = $clog2(MAX_BYTES + 2 ** OFFW + 2);
  localparam int SCW    = $clog2(MAX_STEPS + 1);
  localparam int IXW    = (NENT > 1) ? $clog2(NENT) : 1;

  pstate_e                      fsm_q;
  logic [PW-1:0]                len_q, base_q;
  logic [STW-1:0]               st_q;
  logic [SCW-1:0]               step_q;
  logic                         done_q, err_q;
  entry_t [NENT-1:0]            tbl_q;
  logic [NSTATE-1:0][OFFW-1:0]  laoff_q;

  logic                         busy, pkt_start, coll_wr, win_we, walk;
  logic [BAW-1:0]               win_addr;
  logic [2:0][PW-1:0]           rd_pos;
  logic [2:0][WORDW-1:0]        rd_word;
  logic                         hit;
  logic [STW-1:0]               nxt;
  logic [ADVW-1:0]              adv;
  slot_t                        s0, s1;
  logic [PW-1:0]                nbase;
  logic                         term_ok, last_step, finish, fail;

  assign busy      = (fsm_q != P_IDLE);
  assign pkt_start = (fsm_q == P_IDLE) && in_valid_i && in_sop_i;
  assign coll_wr   = (fsm_q == P_COLL) && in_valid_i && (len_q < PW'(MAX_BYTES));
  assign win_we    = pkt_start || coll_wr;
  assign win_addr  = pkt_start ? '0 : len_q[BAW-1:0];
  assign walk      = (fsm_q == P_WALK);

  assign rd_pos[0] = base_q + PW'(laoff_q[st_q]);
  assign rd_pos[1] = base_q + PW'(s0.off);
  assign rd_pos[2] = base_q + PW'(s1.off);

  hp_window #(.DEPTH(MAX_BYTES), .PW(PW), .NRD(3)) u_win (
    .clk_i     (clk_i),
    .we_i      (win_we),
    .waddr_i   (win_addr),
    .wdata_i   (in_data_i),
    .len_i     (len_q),
    .rd_pos_i  (rd_pos),
    .rd_word_o (rd_word)
  );

  hp_tcam #(.NENT(NENT)) u_tcam (
    .tbl_i (tbl_q),
    .key_i ({st_q, rd_word[0]}),
    .hit_o (hit),
    .nxt_o (nxt),
    .adv_o (adv),
    .s0_o  (s0),
    .s1_o  (s1)
  );

  assign nbase     = base_q + PW'(adv);
  assign term_ok   = (nxt == END_ST) || (nbase >= len_q);
  assign last_step = (step_q == SCW'(MAX_STEPS - 1));
  assign finish    = walk && (!hit || term_ok || last_step);
  assign fail      = walk && (!hit || (!term_ok && last_step));

  hp_phv #(.NWORDS(NWORDS)) u_phv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pkt_start),
    .we0_i  (walk && hit && s0.en),
    .idx0_i (s0.idx),
    .dat0_i (rd_word[1]),
    .we1_i  (walk && hit && s1.en),
    .idx1_i (s1.idx),
    .dat1_i (rd_word[2]),
    .phv_o  (phv_o),
    .vld_o  (phv_vld_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= P_IDLE;
      len_q   <= '0;
      base_q  <= '0;
      st_q    <= START_ST;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      tbl_q   <= '0;
      laoff_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (fsm_q)
        P_IDLE: begin
          if (cfg_we_i) begin
            if (cfg_sel_i)
              laoff_q[cfg_addr_i] <= cfg_data_i[OFFW-1:0];
            else if (int'(cfg_addr_i) < NENT)
              tbl_q[cfg_addr_i[IXW-1:0]] <= entry_t'(cfg_data_i);
          end
          if (pkt_start) begin
            len_q  <= PW'(1);
            base_q <= '0;
            st_q   <= START_ST;
            step_q <= '0;
            err_q  <= 1'b0;
            fsm_q  <= in_eop_i ? P_WALK : P_COLL;
          end
        end
        P_COLL: begin
          if (coll_wr) len_q <= len_q + PW'(1);
          if (in_valid_i && in_eop_i) fsm_q <= P_WALK;
        end
        P_WALK: begin
          if (finish) begin
            fsm_q  <= P_IDLE;
            done_q <= 1'b1;
            err_q  <= fail;
          end else begin
            base_q <= nbase;
            st_q   <= nxt;
            step_q <= step_q + SCW'(1);
          end
        end
        default: fsm_q <= P_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/hdr_parser_chk.sv
module hdr_parser_chk
  import hp_pkg::*;
#(
  parameter int NENT      = 8,
  parameter int NSTATE    = 16,
  parameter int MAX_STEPS = 8,
  parameter int SCW       = 4,
  parameter int NWORDS    = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     done_o,
  input logic                     err_o,
  input logic [NWORDS-1:0]        phv_vld_o,
  input logic                     cfg_we_i,
  input logic                     busy,
  input logic                     pkt_start,
  input logic [NENT*ENTRY_W-1:0]  tbl_q,
  input logic [NSTATE*OFFW-1:0]   laoff_q,
  input logic [SCW-1:0]           step_q
);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);

  a_r6_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);

  a_r8_busy_cfg_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && busy) |=> ($stable(tbl_q) && $stable(laoff_q)));

  a_r9_sop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start |=> (phv_vld_o == '0 && !err_o));

  a_r7_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q < SCW'(MAX_STEPS));
endmodule

bind hdr_parser hdr_parser_chk #(
  .NENT(NENT), .NSTATE(NSTATE), .MAX_STEPS(MAX_STEPS), .SCW(SCW), .NWORDS(NWORDS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .err_o     (err_o),
  .phv_vld_o (phv_vld_o),
  .cfg_we_i  (cfg_we_i),
  .busy      (busy),
  .pkt_start (pkt_start),
  .tbl_q     (tbl_q),
  .laoff_q   (laoff_q),
  .step_q    (step_q)
);

// File: tb/hdr_parser_tb.sv
module hdr_parser_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0]   in_data = '0;
  logic         cfg_we = 0, cfg_sel = 0;
  logic [3:0]   cfg_addr = '0;
  logic [70:0]  cfg_data = '0;
  logic         done_o, err_o;
  logic [127:0] phv_o;
  logic [7:0]   phv_vld_o;

  int n_chk = 0, n_fail = 0;

  logic [7:0]  pkt [128];
  logic [3:0]  pend_addr;
  logic [70:0] pend_data;

  typedef struct {
    bit          err;
    logic [7:0]  vld;
    logic [15:0] w [8];
    string       tag;
  } exp_t;
  exp_t expq [$];

  hdr_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop), .in_data_i(in_data),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .done_o(done_o), .err_o(err_o), .phv_o(phv_o), .phv_vld_o(phv_vld_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each parse result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5 unexpected done", 32'(done_o), 32'd0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(err_o == e.err, {e.tag, " err"}, 32'(err_o), 32'(e.err));
        chk(phv_vld_o == e.vld, {e.tag, " vld"}, 32'(phv_vld_o), 32'(e.vld));
        for (int k = 0; k < 8; k++)
          if (e.vld[k])
            chk(phv_o[k*16 +: 16] == e.w[k], $sformatf("%s word%0d", e.tag, k),
                32'(phv_o[k*16 +: 16]), 32'(e.w[k]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // entry image per R10 layout
  function automatic logic [70:0] mk(input bit en, input logic [3:0] vs, input logic [15:0] vl,
      input logic [3:0] ms, input logic [15:0] ml, input logic [3:0] nx, input logic [5:0] adv,
      input bit e1, input logic [2:0] i1, input logic [5:0] o1,
      input bit e0, input logic [2:0] i0, input logic [5:0] o0);
    return {en, vs, vl, ms, ml, nx, adv, e1, i1, o1, e0, i0, o0};
  endfunction

  task automatic cfg_wr(input bit sel, input logic [3:0] a, input logic [70:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = sel; cfg_addr = a; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic send_pkt(input int n, input int inj);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sop = (i == 0); in_eop = (i == n - 1); in_data = pkt[i];
      cfg_we = (i == inj); cfg_sel = 0; cfg_addr = pend_addr; cfg_data = pend_data;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sop = 0; in_eop = 0; cfg_we = 0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  function automatic void build(input logic [15:0] et, input int ppos, input logic [7:0] pv);
    for (int i = 0; i < 128; i++) pkt[i] = 8'(i * 7 + 3);
    pkt[12] = et[15:8];
    pkt[13] = et[7:0];
    if (ppos >= 0) pkt[ppos] = pv;
  endfunction

  function automatic logic [15:0] wd(input int p);
    return {pkt[p], pkt[p+1]};
  endfunction

  function automatic exp_t blank(input string tag);
    exp_t e;
    e.err = 0; e.vld = '0; e.tag = tag;
    for (int k = 0; k < 8; k++) e.w[k] = '0;
    return e;
  endfunction

  function automatic exp_t exp_v4tcp(input string tag);
    exp_t e;
    e = blank(tag);
    e.vld = 8'h3F;
    e.w[0] = 16'h0800; e.w[1] = wd(0); e.w[2] = wd(26);
    e.w[3] = wd(30);   e.w[4] = wd(34); e.w[5] = wd(36);
    return e;
  endfunction

  initial begin
    exp_t e;
    pend_addr = '0; pend_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done_o == 0, "R1 done after reset", 32'(done_o), 0);
    chk(err_o == 0, "R1 err after reset", 32'(err_o), 0);
    chk(phv_vld_o == 0, "R1 vld after reset", 32'(phv_vld_o), 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // R2: empty table, every lookup misses
    build(16'h0800, 23, 8'h06);
    e = blank("R2 all disabled miss"); e.err = 1; expq.push_back(e);
    send_pkt(54, -1); drain();

    // default graph: states 0 eth, 1 v4, 2 v6, 3 tcp, 4 udp, 15 end
    cfg_wr(1, 4'd0, 71'd12);
    cfg_wr(1, 4'd1, 71'd9);
    cfg_wr(1, 4'd2, 71'd6);
    cfg_wr(0, 4'd0, mk(1, 0, 16'h0800, 4'hF, 16'hFFFF, 1, 14, 1, 1, 0, 1, 0, 12));
    cfg_wr(0, 4'd1, mk(1, 0, 16'h86DD, 4'hF, 16'hFFFF, 2, 14, 0, 0, 0, 1, 0, 12));
    cfg_wr(0, 4'd2, mk(1, 1, 16'h0600, 4'hF, 16'hFF00, 3, 20, 1, 3, 16, 1, 2, 12));
    cfg_wr(0, 4'd3, mk(1, 1, 16'h1100, 4'hF, 16'hFF00, 4, 20, 0, 0, 0, 1, 2, 12));
    cfg_wr(0, 4'd4, mk(1, 2, 16'h0600, 4'hF, 16'hFF00, 3, 40, 0, 0, 0, 1, 2, 8));
    cfg_wr(0, 4'd5, mk(1, 3, 16'h0000, 4'hF, 16'h0000, 15, 20, 1, 5, 2, 1, 4, 0));
    cfg_wr(0, 4'd6, mk(1, 4, 16'h0000, 4'hF, 16'h0000, 15, 8, 1, 4, 2, 1, 4, 0));

    // R4 R5: ipv4/tcp, ends on END state
    build(16'h0800, 23, 8'h06);
    expq.push_back(exp_v4tcp("R4 R5 v4tcp"));
    send_pkt(54, -1); drain();

    // R4: udp, both slots into word4, slot1 wins; R9 clears word3/5 from before
    build(16'h0800, 23, 8'h11);
    e = blank("R4 udp slot collision R9");
    e.vld = 8'h17; e.w[0] = 16'h0800; e.w[1] = wd(0); e.w[2] = wd(26); e.w[4] = wd(36);
    expq.push_back(e);
    send_pkt(60, -1); drain();

    // R3: ipv6 lookahead at a different per-state offset
    build(16'h86DD, 20, 8'h06);
    e = blank("R3 v6tcp");
    e.vld = 8'h35; e.w[0] = 16'h86DD; e.w[2] = wd(22); e.w[4] = wd(54); e.w[5] = wd(56);
    expq.push_back(e);
    send_pkt(74, -1); drain();

    // R6: unknown ethertype misses at the first lookup
    build(16'h0806, -1, 8'h00);
    e = blank("R6 arp miss"); e.err = 1; expq.push_back(e);
    send_pkt(42, -1); drain();

    // R3: byte 13 beyond length reads zero although window holds 0x06 there
    build(16'h0806, -1, 8'h00);
    pkt[12] = 8'h08;
    e = blank("R3 zero fill");
    e.vld = 8'h03; e.w[0] = 16'h0800; e.w[1] = wd(0);
    expq.push_back(e);
    send_pkt(13, -1); drain();

    // R6: ipv4 with unsupported protocol keeps eth words
    build(16'h0800, 23, 8'h01);
    e = blank("R6 icmp miss");
    e.err = 1; e.vld = 8'h03; e.w[0] = 16'h0800; e.w[1] = wd(0);
    expq.push_back(e);
    send_pkt(40, -1); drain();
    repeat (3) @(negedge clk);
    chk(err_o == 1, "R9 err holds", 32'(err_o), 1);
    chk(phv_vld_o == 8'h03, "R9 vld holds", 32'(phv_vld_o), 32'h03);
    chk(done_o == 0, "R5 done pulse ended", 32'(done_o), 0);

    // R5: packet ends right after ipv4 header
    build(16'h0800, 23, 8'h06);
    e = blank("R5 truncated");
    e.vld = 8'h0F; e.w[0] = 16'h0800; e.w[1] = wd(0); e.w[2] = wd(26); e.w[3] = wd(30);
    expq.push_back(e);
    send_pkt(34, -1); drain();

    // R8: write disabling entry0 during collection is dropped
    pend_addr = 4'd0; pend_data = '0;
    build(16'h0800, 23, 8'h06);
    expq.push_back(exp_v4tcp("R8 busy write pkt"));
    send_pkt(54, 5); drain();
    expq.push_back(exp_v4tcp("R8 table unchanged"));
    send_pkt(54, -1); drain();

    // R2 priority: catch-all at entry 7 loses to entry 0
    cfg_wr(0, 4'd7, mk(1, 0, 16'h0000, 4'hF, 16'h0000, 15, 14, 0, 0, 0, 1, 0, 12));
    expq.push_back(exp_v4tcp("R2 priority low index"));
    send_pkt(54, -1); drain();
    build(16'h0806, -1, 8'h00);
    e = blank("R2 catch-all hit");
    e.vld = 8'h01; e.w[0] = 16'h0806;
    expq.push_back(e);
    send_pkt(42, -1); drain();

    // R7: self loop with zero advance hits the step limit
    cfg_wr(0, 4'd7, mk(1, 0, 16'h0000, 4'hF, 16'h0000, 0, 0, 0, 0, 0, 1, 0, 12));
    e = blank("R7 step limit");
    e.err = 1; e.vld = 8'h01; e.w[0] = 16'h0806;
    expq.push_back(e);
    send_pkt(42, -1); drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule